// File: doc/BRIEF.md
# Register Subtract and Logic Execute Stage

This block is the execute stage for a small group of fixed 16-bit instructions. It decodes the word, chooses the operands and forms a 32-bit result in one cycle. The operands come from a sixteen-entry general register file. The block is purely combinational. It presents two read indices to the register file and takes back the two values they select.

For each instruction it reports a write-back enable, the destination index, the result and the next value of a single status flag T. The flag's meaning depends on the opcode:

- For the subtract with carry-in, T is the borrow.
- For the overflow-checking subtract, T reports signed overflow.
- For the two test forms, T is a zero-test result.
- For every other supported opcode, T is passed through unchanged.

Opcodes outside this set write nothing and keep T unchanged.

Top module: `exec_alu_t`

## Requirements
- R1: In register forms, bits 11:8 hold the destination index n and bits 7:4 hold the source index m. n drives read port A and the write index, and m drives read port B.
- R2: Word 0011nnnnmmmm1000 writes Rn-Rm into Rn and leaves T unchanged.
- R3: Word 0011nnnnmmmm1010 writes Rn-Rm-T into Rn and sets T to the borrow out of that subtraction.
- R4: Word 0011nnnnmmmm1011 writes Rn-Rm into Rn. T is 1 exactly when the true signed difference does not fit in 32 bits, otherwise 0.
- R5: Words 0010nnnnmmmm1001 (AND), 0010nnnnmmmm1011 (OR) and 0010nnnnmmmm1010 (XOR) write Rn op Rm into Rn and leave T unchanged.
- R6: Word 0110nnnnmmmm0111 writes the bitwise complement of Rm into Rn and leaves T unchanged.
- R7: Word 0010nnnnmmmm1000 writes no register. It sets T to 1 if Rn&Rm is zero and to 0 otherwise.
- R8: Upper bytes 11001001 (AND), 11001011 (OR) and 11001010 (XOR) combine R0 with the zero-extended immediate in bits 7:0. They write the result to index 0 and leave T unchanged.
- R9: Upper byte 11001000 writes no register. It sets T to 1 if R0&imm (immediate zero-extended) is zero and to 0 otherwise.
- R10: Any other word deasserts the write-back enable and returns T unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 16 | Instruction word |
| t_i | input | 1 | Current T flag |
| rf_a_idx_o | output | 4 | Read index for port A (n, or 0 for immediate forms) |
| rf_b_idx_o | output | 4 | Read index for port B (m) |
| rf_a_data_i | input | 32 | Register value at port A |
| rf_b_data_i | input | 32 | Register value at port B |
| wb_en_o | output | 1 | Write-back enable |
| wb_idx_o | output | 4 | Destination register index |
| wb_data_o | output | 32 | Result to write back |
| t_next_o | output | 1 | Next T flag |

## Verification
Every output is a combinational function of the word, T and the two read values, so results are due in the same cycle the word is applied. The bench applies each word just after a falling edge and samples all four outputs a quarter period later. It commits the write-back and the new T into its own register file model on the following rising edge, so the next word sees the updated state. Directed cases cover the following, and random words cover the rest:

- a borrow chained from T;
- overflow at both signed limits;
- zero and non-zero tests;
- the immediate with all ones in R0;
- n equal to m;
- unrecognised words.

// File: rtl/exec_alu_t.sv
module exec_alu_t #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4,
  parameter int IMM_W  = 8
) (
  input  logic [15:0]       instr_i,
  input  logic              t_i,
  output logic [IDX_W-1:0]  rf_a_idx_o,
  output logic [IDX_W-1:0]  rf_b_idx_o,
  input  logic [DATA_W-1:0] rf_a_data_i,
  input  logic [DATA_W-1:0] rf_b_data_i,
  output logic              wb_en_o,
  output logic [IDX_W-1:0]  wb_idx_o,
  output logic [DATA_W-1:0] wb_data_o,
  output logic              t_next_o
);
  typedef enum logic [3:0] {
    K_NONE, K_SUB, K_SUBB, K_SUBV, K_AND, K_OR, K_XOR, K_TST, K_NOT,
    K_ANDI, K_ORI, K_XORI, K_TSTI
  } kind_e;

  localparam int MSB = DATA_W - 1;

  kind_e kind;
  logic  is_imm;
  logic [DATA_W-1:0] opb;
  logic [DATA_W:0]   diff;
  logic [DATA_W-1:0] conj;

  always_comb begin
    kind = K_NONE;
    case (instr_i[15:12])
      4'b0011: case (instr_i[3:0])
        4'b1000: kind = K_SUB;
        4'b1010: kind = K_SUBB;
        4'b1011: kind = K_SUBV;
        default: kind = K_NONE;
      endcase
      4'b0010: case (instr_i[3:0])
        4'b1000: kind = K_TST;
        4'b1001: kind = K_AND;
        4'b1010: kind = K_XOR;
        4'b1011: kind = K_OR;
        default: kind = K_NONE;
      endcase
      4'b0110: if (instr_i[3:0] == 4'b0111) kind = K_NOT;
      4'b1100: case (instr_i[11:8])
        4'b1000: kind = K_TSTI;
        4'b1001: kind = K_ANDI;
        4'b1010: kind = K_XORI;
        4'b1011: kind = K_ORI;
        default: kind = K_NONE;
      endcase
      default: kind = K_NONE;
    endcase
  end

  assign is_imm     = (kind == K_ANDI) || (kind == K_ORI) || (kind == K_XORI) || (kind == K_TSTI);
  assign rf_a_idx_o = is_imm ? '0 : instr_i[11:8];
  assign rf_b_idx_o = instr_i[7:4];
  assign wb_idx_o   = is_imm ? '0 : instr_i[11:8];

  assign opb  = is_imm ? {{(DATA_W-IMM_W){1'b0}}, instr_i[IMM_W-1:0]} : rf_b_data_i;
  assign diff = {1'b0, rf_a_data_i} - {1'b0, opb}
              - {{DATA_W{1'b0}}, (kind == K_SUBB) & t_i};
  assign conj = rf_a_data_i & opb;

  always_comb begin
    wb_en_o   = 1'b1;
    wb_data_o = '0;
    t_next_o  = t_i;
    case (kind)
      K_SUB:  wb_data_o = diff[MSB:0];
      K_SUBB: begin wb_data_o = diff[MSB:0]; t_next_o = diff[DATA_W]; end
      K_SUBV: begin
        wb_data_o = diff[MSB:0];
        t_next_o  = (rf_a_data_i[MSB] ^ opb[MSB]) & (diff[MSB] ^ rf_a_data_i[MSB]);
      end
      K_AND, K_ANDI: wb_data_o = conj;
      K_OR,  K_ORI:  wb_data_o = rf_a_data_i | opb;
      K_XOR, K_XORI: wb_data_o = rf_a_data_i ^ opb;
      K_NOT:         wb_data_o = ~rf_b_data_i;
      K_TST, K_TSTI: begin wb_en_o = 1'b0; t_next_o = (conj == '0); end
      default:       wb_en_o = 1'b0;
    endcase
  end

  always_comb begin
    if (is_imm) begin
      p_imm_dest_r8: assert (wb_idx_o == '0 && rf_a_idx_o == '0);
    end
    if (kind == K_TST || kind == K_TSTI) begin
      p_test_nowrite_r7: assert (!wb_en_o);
    end
    if (kind == K_NONE) begin
      p_unknown_quiet_r10: assert (!wb_en_o && t_next_o == t_i);
    end
    if (kind == K_SUB || kind == K_NOT || kind == K_AND || kind == K_OR || kind == K_XOR) begin
      p_flag_kept_r2: assert (t_next_o == t_i && wb_en_o);
    end
    if (kind == K_SUBV && rf_a_data_i[MSB] == rf_b_data_i[MSB]) begin
      p_no_overflow_r4: assert (!t_next_o);
    end
    if (kind == K_SUBB && !t_i && rf_a_data_i >= rf_b_data_i) begin
      p_no_borrow_r3: assert (!t_next_o);
    end
  end
endmodule

// File: tb/exec_alu_t_tb.sv
module exec_alu_t_tb_top;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_P/2) clk = ~clk;

  logic [15:0] instr;
  logic        t_cur;
  logic [3:0]  a_idx, b_idx, wb_idx;
  logic [31:0] a_dat, b_dat, wb_dat;
  logic        wb_en, t_nx;
  logic [31:0] regs [16];

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  assign a_dat = regs[a_idx];
  assign b_dat = regs[b_idx];

  exec_alu_t dut_i (
    .instr_i(instr), .t_i(t_cur),
    .rf_a_idx_o(a_idx), .rf_b_idx_o(b_idx),
    .rf_a_data_i(a_dat), .rf_b_data_i(b_dat),
    .wb_en_o(wb_en), .wb_idx_o(wb_idx), .wb_data_o(wb_dat), .t_next_o(t_nx)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s instr=%h actual=%h expected=%h", req, what, instr, act, exp);
    end
  endtask

  task automatic model(input logic [15:0] w, output string req, output bit en,
                       output logic [3:0] idx, output logic [31:0] res, output bit tn);
    logic [31:0] rn, rm, r0, imm;
    longint sd;
    rn = regs[w[11:8]]; rm = regs[w[7:4]]; r0 = regs[0]; imm = {24'd0, w[7:0]};
    en = 1; idx = w[11:8]; res = 0; tn = t_cur; req = "R10";
    casez (w)
      16'b0011_????_????_1000: begin req = "R2"; res = rn - rm; end
      16'b0011_????_????_1010: begin
        req = "R3"; res = rn - rm - {31'd0, t_cur};
        tn = ({32'd0, rn} < {32'd0, rm} + {63'd0, t_cur});
      end
      16'b0011_????_????_1011: begin
        req = "R4"; res = rn - rm;
        sd = longint'($signed(rn)) - longint'($signed(rm));
        tn = (sd > 64'sd2147483647) || (sd < -64'sd2147483648);
      end
      16'b0010_????_????_1001: begin req = "R5"; res = rn & rm; end
      16'b0010_????_????_1011: begin req = "R5"; res = rn | rm; end
      16'b0010_????_????_1010: begin req = "R5"; res = rn ^ rm; end
      16'b0010_????_????_1000: begin req = "R7"; en = 0; tn = ((rn & rm) == 0); end
      16'b0110_????_????_0111: begin req = "R6"; res = ~rm; end
      16'b11001001_????????:   begin req = "R8"; idx = 0; res = r0 & imm; end
      16'b11001011_????????:   begin req = "R8"; idx = 0; res = r0 | imm; end
      16'b11001010_????????:   begin req = "R8"; idx = 0; res = r0 ^ imm; end
      16'b11001000_????????:   begin req = "R9"; en = 0; tn = ((r0 & imm) == 0); end
      default: en = 0;
    endcase
  endtask

  task automatic run(input logic [15:0] w);
    string req; bit en, tn; logic [3:0] idx; logic [31:0] res;
    @(negedge clk);
    instr = w;
    #(CLK_P/4);
    model(w, req, en, idx, res, tn);
    chk(req, "wb_en", {31'd0, wb_en}, {31'd0, en});
    chk(req, "t_next", {31'd0, t_nx}, {31'd0, tn});
    if (en) begin
      chk(req, "wb_data", wb_dat, res);
      chk(req, "wb_idx", {28'd0, wb_idx}, {28'd0, idx});
    end
    if (w[15:12] != 4'b1100) begin
      chk("R1", "a_idx", {28'd0, a_idx}, {28'd0, w[11:8]});
      chk("R1", "b_idx", {28'd0, b_idx}, {28'd0, w[7:4]});
    end
    @(posedge clk);
    if (wb_en) regs[wb_idx] = wb_dat;
    t_cur = t_nx;
  endtask

  function automatic logic [15:0] rnd_word();
    logic [3:0] n, m; logic [7:0] imm;
    n = 4'($urandom); m = 4'($urandom); imm = 8'($urandom);
    case ($urandom % 14)
      0: return {4'b0011, n, m, 4'b1000};
      1: return {4'b0011, n, m, 4'b1010};
      2: return {4'b0011, n, m, 4'b1011};
      3: return {4'b0010, n, m, 4'b1001};
      4: return {4'b0010, n, m, 4'b1011};
      5: return {4'b0010, n, m, 4'b1010};
      6: return {4'b0010, n, m, 4'b1000};
      7: return {4'b0110, n, m, 4'b0111};
      8: return {8'b11001001, imm};
      9: return {8'b11001011, imm};
      10: return {8'b11001010, imm};
      11: return {8'b11001000, imm};
      default: return 16'($urandom);
    endcase
  endfunction

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed1234));
    instr = 16'h0000;
    t_cur = 1'b0;
    for (int i = 0; i < 16; i++) regs[i] = $urandom;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    #1;
    chk("R10", "reset wb_en", {31'd0, wb_en}, 32'd0);
    chk("R10", "reset t_next", {31'd0, t_nx}, 32'd0);

    regs[1] = 0; regs[2] = 0; t_cur = 1;
    run(16'h312A);
    chk("R3", "borrow chain result", regs[1], 32'hFFFF_FFFF);
    chk("R3", "borrow chain T", {31'd0, t_cur}, 32'd1);
    regs[3] = 32'h8000_0000; regs[4] = 1;
    run(16'h334B);
    regs[3] = 32'h7FFF_FFFF; regs[4] = 32'hFFFF_FFFF;
    run(16'h334B);
    regs[3] = 5; regs[4] = 7;
    run(16'h334B);
    regs[5] = 32'hF0F0_F0F0; regs[6] = 32'h0F0F_0F0F;
    run(16'h2568);
    regs[6] = 32'h0000_0010;
    run(16'h2568);
    regs[0] = 32'hFFFF_FFFF;
    run(16'hC9FF);
    chk("R8", "imm zero-extended", regs[0], 32'h0000_00FF);
    run(16'hC800);
    run(16'hC80F);
    regs[7] = 32'h1234_5678;
    run(16'h3778);
    chk("R1", "n equals m", regs[7], 32'd0);
    run(16'h6787);
    t_cur = 1;
    run(16'h300F);
    run(16'hCC12);
    run(16'h6781);
    run(16'h3128);

    for (int i = 0; i < 3000; i++) begin
      if ((i % 7) == 0) t_cur = 1'($urandom);
      run(rnd_word());
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule